// File: doc/BRIEF.md
# Byte-Granular Funnel Align Unit

This block joins two 64-bit vector operands into a 128-bit value, with the first operand in the upper half, and returns a 64-bit window of it taken at a byte offset. The result is the first operand shifted left by eight times the offset. The bytes that this shift vacates at the bottom are filled from the top of the second operand. An execution pipeline uses it to realign packed data that crosses a word boundary.

The byte offset comes from one of two sources. It can be a 3-bit immediate, or it can be the low three bits of a 64-bit general-register value. A select input picks the source on each request. A format bit travels with each request so that the neighbouring decode can check it for legality. The data path ignores it. A request is accepted on any cycle that carries the input strobe, and its result is registered one cycle later.

Top module: `byte_funnel_align`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` is 1 in the cycle after a cycle with `req_valid` high, and 0 in the cycle after a cycle with `req_valid` low.
- R3: When `ofs_src` is 0, the byte offset k is `imm_ofs`, and the result is `(opnd_a << 8k) | (opnd_b >> (64 - 8k))` for k from 1 to 7.
- R4: When `ofs_src` is 1, the byte offset k is `reg_val[2:0]`, and the result follows the R3 formula. Bits 63:3 of `reg_val` have no effect on the result.
- R5: With an effective offset of zero, the result equals `opnd_a` bit for bit, and no bit of `opnd_b` appears in it.
- R6: `fmt_sel` has no effect on `res_data` for either value.
- R7: Byte i of a word is bits 8i+7:8i, so byte 7 is bits 63:56. For an offset k greater than 0, byte 0 of the result is byte 8-k of `opnd_b`, and byte k of the result is byte 0 of `opnd_a`.
- R8: In a cycle that follows a cycle with `req_valid` low, `res_data` keeps its previous value.
- R9: Requests on consecutive cycles each produce their own result one cycle later, in the order they were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| ofs_src | input | 1 | Offset source: 0 selects the immediate, 1 selects the register |
| imm_ofs | input | 3 | Immediate byte offset |
| reg_val | input | 64 | General-register value; only bits 2:0 are used |
| fmt_sel | input | 1 | Format bit; checked elsewhere for legality, no effect on data |
| opnd_a | input | 64 | First operand, the upper half of the concatenation |
| opnd_b | input | 64 | Second operand, the lower half of the concatenation |
| res_valid | output | 1 | Result valid, one cycle after `req_valid` |
| res_data | output | 64 | Aligned 64-bit result |

## Verification
Selecting the offset source and ignoring the high register bits happen in the same cycle. The bench therefore drives immediate-form requests while `reg_val` carries random values whose low bits differ from the immediate. It also drives register-form requests whose high bits are random. In each case the result must match the offset from the selected source only. A new request can also arrive in the same cycle that the previous result is presented, so back-to-back requests with different offsets are issued. Each output cycle is compared against the result expected for its own request.

// File: rtl/byte_funnel_align_pkg.sv
package byte_funnel_align_pkg;
    localparam int DATA_W = 64;
    localparam int BYTE_W = 8;
    localparam int LANES  = DATA_W / BYTE_W;
    localparam int OFS_W  = $clog2(LANES);

    typedef enum logic {
        SRC_IMM = 1'b0,
        SRC_REG = 1'b1
    } ofs_src_e;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic [OFS_W-1:0]  ofs;
    } align_req_t;

    function automatic logic [OFS_W-1:0] pick_ofs(ofs_src_e src,
                                                  logic [OFS_W-1:0] imm,
                                                  logic [OFS_W-1:0] reg_low);
        return (src == SRC_REG) ? reg_low : imm;
    endfunction
endpackage

// File: rtl/align_ofs_sel.sv
module align_ofs_sel
    import byte_funnel_align_pkg::*;
#(
    parameter int REG_W = DATA_W
) (
    input  logic             ofs_src,
    input  logic [OFS_W-1:0] imm_ofs,
    input  logic [REG_W-1:0] reg_val,
    output logic [OFS_W-1:0] ofs
);
    ofs_src_e src;
    logic     unused_reg_hi;

    assign src           = ofs_src_e'(ofs_src);
    assign ofs           = pick_ofs(src, imm_ofs, reg_val[OFS_W-1:0]);
    assign unused_reg_hi = ^reg_val[REG_W-1:OFS_W];
endmodule

// File: rtl/align_funnel.sv
module align_funnel
    import byte_funnel_align_pkg::*;
(
    input  align_req_t        req,
    output logic [DATA_W-1:0] res
);
    logic [2*DATA_W-1:0] joined;
    assign joined = {req.hi, req.lo};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            int src_lane;
            src_lane = LANES + i - int'(req.ofs);
            res[i*BYTE_W +: BYTE_W] = joined[src_lane*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/align_out_reg.sv
module align_out_reg
    import byte_funnel_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              vld,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            dout <= '0;
        end else begin
            vld <= load;
            if (load) dout <= din;
        end
    end
endmodule

// File: rtl/byte_funnel_align.sv
module byte_funnel_align
    import byte_funnel_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              ofs_src,
    input  logic [OFS_W-1:0]  imm_ofs,
    input  logic [DATA_W-1:0] reg_val,
    input  logic              fmt_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    align_req_t        req;
    logic [OFS_W-1:0]  ofs;
    logic [DATA_W-1:0] aligned;
    logic              unused_fmt;

    assign unused_fmt = fmt_sel;

    align_ofs_sel #(.REG_W(DATA_W)) i_ofs (
        .ofs_src (ofs_src),
        .imm_ofs (imm_ofs),
        .reg_val (reg_val),
        .ofs     (ofs)
    );

    assign req = '{hi: opnd_a, lo: opnd_b, ofs: ofs};

    align_funnel i_funnel (
        .req (req),
        .res (aligned)
    );

    align_out_reg i_oreg (
        .clk  (clk),
        .rst  (rst),
        .load (req_valid),
        .din  (aligned),
        .vld  (res_valid),
        .dout (res_data)
    );
endmodule

// File: rtl/byte_funnel_align_chk.sv
module byte_funnel_align_chk
    import byte_funnel_align_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              ofs_src,
    input logic [OFS_W-1:0]  imm_ofs,
    input logic [DATA_W-1:0] reg_val,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data
);
    logic [OFS_W-1:0]  k;
    logic [BYTE_W-1:0] b_byte;
    logic [DATA_W-1:0] b_shr;
    logic              unused_hi;

    assign unused_hi = ^reg_val[DATA_W-1:OFS_W];
    assign k = ofs_src ? reg_val[OFS_W-1:0] : imm_ofs;

    always_comb begin
        int sh;
        sh     = DATA_W - BYTE_W * int'(k);
        b_shr  = opnd_b >> sh;
        b_byte = b_shr[BYTE_W-1:0];
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!res_valid && res_data == '0));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    p_idle_follows_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);

    p_zero_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && k == '0) |=> (res_data == $past(opnd_a)));

    p_low_byte_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && k != '0) |=> (res_data[BYTE_W-1:0] == $past(b_byte)));

    p_hold_data_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(res_data));
endmodule

bind byte_funnel_align byte_funnel_align_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ofs_src   (ofs_src),
    .imm_ofs   (imm_ofs),
    .reg_val   (reg_val),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/test_byte_funnel_align.sv
`timescale 1ns/1ps
module test_byte_funnel_align;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        ofs_src = 1'b0;
    logic [2:0]  imm_ofs = '0;
    logic [63:0] reg_val = '0;
    logic        fmt_sel = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        res_valid;
    logic [63:0] res_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    byte_funnel_align i_byte_funnel_align (
        .clk(clk), .rst(rst), .req_valid(req_valid), .ofs_src(ofs_src),
        .imm_ofs(imm_ofs), .reg_val(reg_val), .fmt_sel(fmt_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, int k);
        if (k == 0) return a;
        return (a << (8 * k)) | (b >> (64 - 8 * k));
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Caller is at a negedge; result is checked at the following negedge.
    task automatic issue(string tag, bit src, logic [2:0] imm, logic [63:0] rv,
                         bit fmt, logic [63:0] a, logic [63:0] b, bit clear);
        int k;
        req_valid = 1'b1; ofs_src = src; imm_ofs = imm; reg_val = rv;
        fmt_sel = fmt; opnd_a = a; opnd_b = b;
        k = src ? int'(rv[2:0]) : int'(imm);
        @(negedge clk);
        check({tag, " valid"}, {63'd0, res_valid}, 64'd1);
        check(tag, res_data, model(a, b, k));
        if (clear) req_valid = 1'b0;
    endtask

    function automatic logic [63:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b, held;
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        check("R1 reset valid", {63'd0, res_valid}, 64'd0);
        check("R1 reset data", res_data, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        check("R1 after reset valid", {63'd0, res_valid}, 64'd0);
        check("R1 after reset data", res_data, 64'd0);

        a = 64'h0706_0504_0302_0100;
        b = 64'h0f0e_0d0c_0b0a_0908;
        for (int k = 0; k < 8; k++) begin
            issue("R3 immediate sweep", 1'b0, 3'(k), ~64'(k), 1'b0, a, b, 1'b1);
            check("R7 low byte from b", {56'd0, res_data[7:0]},
                  (k == 0) ? {56'd0, a[7:0]} : {56'd0, b[(8-k)*8 +: 8]});
            check("R7 byte k is a byte 0", {56'd0, res_data[k*8 +: 8]}, {56'd0, a[7:0]});
            issue("R4 register sweep", 1'b1, 3'(7 - k), {61'h1abc_dead_beef_0123, 3'(k)},
                  1'b0, a, b, 1'b1);
        end

        issue("R5 zero imm", 1'b0, 3'd0, r64(), 1'b0, 64'h8000_0000_0000_0001, '1, 1'b1);
        issue("R5 zero reg", 1'b1, 3'd5, {r64() & ~64'h7}, 1'b1, 64'h0123_4567_89ab_cdef, '1, 1'b1);

        a = r64(); b = r64();
        issue("R6 fmt 0", 1'b0, 3'd3, r64(), 1'b0, a, b, 1'b1);
        issue("R6 fmt 1", 1'b0, 3'd3, r64(), 1'b1, a, b, 1'b1);

        held = res_data;
        opnd_a = r64(); opnd_b = r64(); imm_ofs = 3'd6;
        @(negedge clk);
        check("R2 idle valid", {63'd0, res_valid}, 64'd0);
        check("R8 hold data", res_data, held);
        @(negedge clk);
        check("R8 hold data second cycle", res_data, held);

        issue("R9 back-to-back 1", 1'b0, 3'd1, r64(), 1'b0, r64(), r64(), 1'b0);
        issue("R9 back-to-back 2", 1'b1, 3'd7, {r64()[63:3], 3'd2}, 1'b1, r64(), r64(), 1'b0);
        issue("R9 back-to-back 3", 1'b0, 3'd0, r64(), 1'b0, r64(), r64(), 1'b1);

        for (int n = 0; n < 400; n++) begin
            bit src;
            src = 1'($urandom());
            issue(src ? "R4 random reg" : "R3 random imm", src, 3'($urandom()), r64(),
                  1'($urandom()), r64(), r64(), 1'($urandom()));
            if (!req_valid) begin
                held = res_data;
                @(negedge clk);
                check("R2 random idle", {63'd0, res_valid}, 64'd0);
                check("R8 random hold", res_data, held);
            end
        end

        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 re-reset valid", {63'd0, res_valid}, 64'd0);
        check("R1 re-reset data", res_data, 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule